// File: doc/BRIEF.md
# Auto-Reload Timer with Clock Select

This block is a 16-bit up-counter that advances on single-cycle count enables from one of three sources. The first is every system clock. The second is every twelfth system clock, taken from a free-running prescaler. The third is every eighth rising edge of an asynchronous external oscillator input, which is first brought into the system clock domain. When the counter passes 0xFFFF, it reloads a programmed 16-bit start value and sets a sticky high-overflow flag. It also emits a one-cycle pulse that other logic, such as a converter, can use as a trigger.

Every time the low byte wraps from 0xFF to 0x00, the block sets a sticky low-overflow flag. An interrupt line combines the high flag with the low flag, when the low flag is enabled, and only passes the result when the interrupt enable is set. Software reaches the count, the reload value and a control byte through a small byte-wide register port. Writes take effect on the clock edge, and reads are combinational.

Top module: `tmr_reload_timer`

## Requirements
- R1: After reset the count and reload value are 0x0000, both flags, run and both enables are 0, and the source field holds 1 (divide-by-12), so the control byte reads 0x02. `irq` and `ovf_pulse` are low.
- R2: Register map on `wr_addr`/`rd_addr`: 0 is the count low byte, 1 the count high byte, 2 the reload low byte, 3 the reload high byte, 4 the control byte. Control bits are: bit0 run, bits2:1 source (0 system clock, 1 clock/12, 2 external/8, 3 no count), bit3 interrupt enable, bit4 low-overflow interrupt enable, bit6 low flag, bit7 high flag. Any other address reads 0.
- R3: With source 0 and run set, the count rises by exactly one on every clock edge. With run clear, the count does not change.
- R4: With source 1, any 120 consecutive clock edges with run set add exactly 10 to the count.
- R5: With source 2, the count rises by one for every eight rising edges of `ext_clk`, each seen after a two-flop synchronizer. Seven edges leave the count unchanged.
- R6: An increment from 0xFFFF loads the reload value instead of 0x0000 and sets the high flag on that same edge.
- R7: `ovf_pulse` is high for exactly the one cycle after each edge on which the 16-bit overflow happened.
- R8: Every low-byte wrap from 0xFF to 0x00 sets the low flag. A wrap with a nonzero high byte sets neither the high flag nor `ovf_pulse`.
- R9: `irq` is high when the interrupt enable is set and either the high flag is set, or the low flag and the low-overflow enable are both set.
- R10: The flags are sticky. A control write clears a flag whose bit is written as 0 and leaves a flag whose bit is written as 1 unchanged.
- R11: A count write loads the written byte on that edge, leaves the other byte unchanged, and suppresses that edge's increment. Reload writes read back on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | Asynchronous external oscillator |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Combinational read data |
| irq | output | 1 | Interrupt request |
| ovf_pulse | output | 1 | One-cycle 16-bit overflow trigger |

## Verification
Register writes, increments, reloads and flag updates all land on the edge that performs the write or the increment. Reads, and `irq`, follow the registered state combinationally, so every check reads one time unit after the edge of interest. The bench counts system edges from the edge that sets run to the edge that clears it, and that edge still counts. It compares the count with the number of source ticks in that window, 120 edges giving 10 divide-by-12 ticks. An external edge needs three system edges to reach the tick logic, so external checks wait six cycles after the last edge. `ovf_pulse` is checked in the cycle right after the overflow edge and again one cycle later.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;

    typedef enum logic [1:0] {
        SRC_SYS   = 2'd0,
        SRC_DIV12 = 2'd1,
        SRC_EXT8  = 2'd2,
        SRC_OFF   = 2'd3
    } src_e;

    typedef struct packed {
        logic run;
        src_e src;
        logic irq_en;
        logic low_en;
    } cfg_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } flags_t;

    function automatic logic [BYTE_W-1:0] pack_ctrl(cfg_t c, flags_t f);
        return {f.hi, f.lo, 1'b0, c.low_en, c.irq_en, c.src, c.run};
    endfunction

    function automatic cfg_t unpack_cfg(logic [BYTE_W-1:0] d);
        cfg_t c;
        c.run    = d[0];
        c.src    = src_e'(d[2:1]);
        c.irq_en = d[3];
        c.low_en = d[4];
        return c;
    endfunction
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
    import tmr_pkg::*;
#(
    parameter int DIV_SLOW = 12,
    parameter int DIV_EXT  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_clk,
    input  src_e src,
    output logic tick
);
    localparam int PW = $clog2(DIV_SLOW);
    localparam int EW = $clog2(DIV_EXT);

    logic [PW-1:0] pre_q;
    logic [EW-1:0] ext_q;
    logic [2:0]    sync_q;
    logic          ext_rise;
    logic          slow_tick;
    logic          ext_tick;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else if (pre_q == PW'(DIV_SLOW - 1)) pre_q <= '0;
        else pre_q <= pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else sync_q <= {sync_q[1:0], ext_clk};
    end

    assign ext_rise = sync_q[1] & ~sync_q[2];

    always_ff @(posedge clk) begin
        if (rst) ext_q <= '0;
        else if (ext_rise) begin
            if (ext_q == EW'(DIV_EXT - 1)) ext_q <= '0;
            else ext_q <= ext_q + 1'b1;
        end
    end

    assign slow_tick = (pre_q == PW'(DIV_SLOW - 1));
    assign ext_tick  = ext_rise && (ext_q == EW'(DIV_EXT - 1));

    always_comb begin
        case (src)
            SRC_SYS:   tick = 1'b1;
            SRC_DIV12: tick = slow_tick;
            SRC_EXT8:  tick = ext_tick;
            default:   tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic              cnt_wr_lo,
    input  logic              cnt_wr_hi,
    input  logic              rld_wr_lo,
    input  logic              rld_wr_hi,
    input  logic              flag_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  reload,
    output flags_t            flags,
    output logic              ovf
);
    logic inc, hi_roll, lo_roll;
    logic keep_hi, keep_lo;

    assign inc     = run & tick & ~(cnt_wr_lo | cnt_wr_hi);
    assign hi_roll = inc && (count == {CNT_W{1'b1}});
    assign lo_roll = inc && (count[BYTE_W-1:0] == {BYTE_W{1'b1}});
    assign keep_hi = ~flag_wr | wdata[7];
    assign keep_lo = ~flag_wr | wdata[6];

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (cnt_wr_lo || cnt_wr_hi) begin
            if (cnt_wr_lo) count[BYTE_W-1:0]     <= wdata;
            if (cnt_wr_hi) count[CNT_W-1:BYTE_W] <= wdata;
        end else if (hi_roll) begin
            count <= reload;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload <= '0;
        end else begin
            if (rld_wr_lo) reload[BYTE_W-1:0]     <= wdata;
            if (rld_wr_hi) reload[CNT_W-1:BYTE_W] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            ovf   <= 1'b0;
        end else begin
            flags.hi <= hi_roll | (flags.hi & keep_hi);
            flags.lo <= lo_roll | (flags.lo & keep_lo);
            ovf      <= hi_roll;
        end
    end
endmodule

// File: rtl/tmr_reload_timer.sv
module tmr_reload_timer
    import tmr_pkg::*;
#(
    parameter int DIV_SLOW = 12,
    parameter int DIV_EXT  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              irq,
    output logic              ovf_pulse
);
    cfg_t             cfg;
    flags_t           flags;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] reload;
    logic             tick;
    logic             cnt_wr_lo, cnt_wr_hi, flag_wr;

    assign cnt_wr_lo = wr_en && (wr_addr == A_CNT_LO);
    assign cnt_wr_hi = wr_en && (wr_addr == A_CNT_HI);
    assign flag_wr   = wr_en && (wr_addr == A_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            cfg.src <= SRC_DIV12;
        end else if (flag_wr) begin
            cfg <= unpack_cfg(wr_data);
        end
    end

    tmr_tick_gen #(.DIV_SLOW(DIV_SLOW), .DIV_EXT(DIV_EXT)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .ext_clk (ext_clk),
        .src     (cfg.src),
        .tick    (tick)
    );

    tmr_core u_core (
        .clk       (clk),
        .rst       (rst),
        .run       (cfg.run),
        .tick      (tick),
        .cnt_wr_lo (cnt_wr_lo),
        .cnt_wr_hi (cnt_wr_hi),
        .rld_wr_lo (wr_en && (wr_addr == A_RLD_LO)),
        .rld_wr_hi (wr_en && (wr_addr == A_RLD_HI)),
        .flag_wr   (flag_wr),
        .wdata     (wr_data),
        .count     (count),
        .reload    (reload),
        .flags     (flags),
        .ovf       (ovf_pulse)
    );

    always_comb begin
        case (rd_addr)
            A_CNT_LO: rd_data = count[BYTE_W-1:0];
            A_CNT_HI: rd_data = count[CNT_W-1:BYTE_W];
            A_RLD_LO: rd_data = reload[BYTE_W-1:0];
            A_RLD_HI: rd_data = reload[CNT_W-1:BYTE_W];
            A_CTRL:   rd_data = pack_ctrl(cfg, flags);
            default:  rd_data = '0;
        endcase
    end

    assign irq = cfg.irq_en & (flags.hi | (flags.lo & cfg.low_en));
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
    import tmr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload,
    input logic             run,
    input logic             tick,
    input logic             cnt_wr,
    input logic             flag_wr,
    input logic             flag_hi,
    input logic             irq_en,
    input logic             irq,
    input logic             ovf_pulse
);
    // R6
    reload_load_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> (count == $past(reload)) && flag_hi);

    // R3
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(count));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !cnt_wr && count != {CNT_W{1'b1}}) |=>
            count == CNT_W'($past(count) + 1'b1));

    // R10
    sticky_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_hi && !flag_wr) |=> flag_hi);

    // R9
    irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_en && flag_hi) |-> irq);

    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> !ovf_pulse);
endmodule

bind tmr_reload_timer tmr_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .count     (count),
    .reload    (reload),
    .run       (cfg.run),
    .tick      (tick),
    .cnt_wr    (cnt_wr_lo | cnt_wr_hi),
    .flag_wr   (flag_wr),
    .flag_hi   (flags.hi),
    .irq_en    (cfg.irq_en),
    .irq       (irq),
    .ovf_pulse (ovf_pulse)
);

// File: tb/sim_tmr_reload_timer.sv
module sim_tmr_reload_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_clk = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq, ovf_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    tmr_reload_timer u0 (
        .clk(clk), .rst(rst), .ext_clk(ext_clk),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .irq(irq), .ovf_pulse(ovf_pulse)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic rd_cnt(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(3'd0, lo);
        rd(3'd1, hi);
        v = {hi, lo};
    endtask

    task automatic set_cnt(logic [15:0] v);
        wr(3'd0, v[7:0]);
        wr(3'd1, v[15:8]);
    endtask

    task automatic ext_edges(int n);
        repeat (n) begin
            ext_clk = 1'b1; cycles(3);
            ext_clk = 1'b0; cycles(3);
        end
    endtask

    task automatic t_reset;
        logic [7:0]  d;
        logic [15:0] v;
        rd_cnt(v);            check("R1 count", v, 16'h0000);
        rd(3'd2, d);          check("R1 reload lo", {8'h0, d}, 16'h0000);
        rd(3'd3, d);          check("R1 reload hi", {8'h0, d}, 16'h0000);
        rd(3'd4, d);          check("R1 ctrl", {8'h0, d}, 16'h0002);
        rd(3'd6, d);          check("R2 unmapped", {8'h0, d}, 16'h0000);
        check("R1 irq", {15'h0, irq}, 16'h0);
        check("R1 ovf_pulse", {15'h0, ovf_pulse}, 16'h0);
    endtask

    task automatic t_sys;
        logic [15:0] v;
        set_cnt(16'h0000);
        wr(3'd4, 8'hC1);
        cycles(9);
        rd_cnt(v);            check("R3 sys run", v, 16'd9);
        wr(3'd4, 8'hC0);
        cycles(5);
        rd_cnt(v);            check("R3 stopped hold", v, 16'd10);
    endtask

    task automatic t_div12;
        logic [15:0] v;
        set_cnt(16'h0000);
        wr(3'd4, 8'hC3);
        cycles(119);
        wr(3'd4, 8'hC2);
        rd_cnt(v);            check("R4 div12 ticks", v, 16'd10);
    endtask

    task automatic t_ext;
        logic [15:0] v;
        set_cnt(16'h0000);
        wr(3'd4, 8'hC5);
        ext_edges(7); cycles(6);
        rd_cnt(v);            check("R5 seven edges", v, 16'd0);
        ext_edges(1); cycles(6);
        rd_cnt(v);            check("R5 eighth edge", v, 16'd1);
        ext_edges(8); cycles(6);
        rd_cnt(v);            check("R5 sixteen edges", v, 16'd2);
        wr(3'd4, 8'hC4);
    endtask

    task automatic t_overflow;
        logic [7:0]  d;
        logic [15:0] v;
        wr(3'd2, 8'h34);
        wr(3'd3, 8'h12);
        rd(3'd2, d);          check("R11 reload lo", {8'h0, d}, 16'h0034);
        rd(3'd3, d);          check("R11 reload hi", {8'h0, d}, 16'h0012);
        set_cnt(16'hFFFE);
        wr(3'd4, 8'hC9);
        cycles(1);
        rd_cnt(v);            check("R6 before wrap", v, 16'hFFFF);
        check("R7 no early pulse", {15'h0, ovf_pulse}, 16'h0);
        cycles(1);
        rd_cnt(v);            check("R6 reloaded", v, 16'h1234);
        check("R7 pulse", {15'h0, ovf_pulse}, 16'h1);
        check("R9 irq hi", {15'h0, irq}, 16'h1);
        cycles(1);
        check("R7 pulse one cycle", {15'h0, ovf_pulse}, 16'h0);
        rd_cnt(v);            check("R6 counts on", v, 16'h1235);
        wr(3'd4, 8'hC8);
        check("R10 keep on 1", {15'h0, irq}, 16'h1);
        wr(3'd4, 8'h48);
        check("R10 clear on 0", {15'h0, irq}, 16'h0);
        rd(3'd4, d);          check("R10 ctrl flags", {8'h0, d}, 16'h0048);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_low;
        logic [7:0]  d;
        logic [15:0] v;
        set_cnt(16'h00FE);
        wr(3'd4, 8'h19);
        cycles(2);
        rd_cnt(v);            check("R8 low wrap", v, 16'h0100);
        check("R8 no pulse", {15'h0, ovf_pulse}, 16'h0);
        check("R9 irq low", {15'h0, irq}, 16'h1);
        rd(3'd4, d);          check("R8 low flag only", {8'h0, d}, 16'h0059);
        wr(3'd4, 8'hC8);
        check("R9 low masked", {15'h0, irq}, 16'h0);
        wr(3'd4, 8'hD0);
        check("R9 irq gated", {15'h0, irq}, 16'h0);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_prio;
        logic [15:0] v;
        set_cnt(16'h0010);
        wr(3'd4, 8'h01);
        cycles(2);
        rd_cnt(v);            check("R3 pre write", v, 16'h0012);
        wr(3'd0, 8'hA0);
        rd_cnt(v);            check("R11 write wins", v, 16'h00A0);
        cycles(1);
        rd_cnt(v);            check("R11 resumes", v, 16'h00A1);
        wr(3'd4, 8'h00);
        rd_cnt(v);            check("R3 last edge", v, 16'h00A2);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        cycles(3);
        rst = 1'b0;
        cycles(1);
        t_reset;
        t_sys;
        t_div12;
        t_ext;
        t_overflow;
        t_low;
        t_prio;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule